// File: doc/BRIEF.md
# Sticky Fault Status with Stop-Preserving I/O Watchdog

This block collects fault conditions from the rest of a node into a register of sticky status bits. Once a condition has been seen, its bit stays set until software acknowledges it. A mask register chooses which of these bits feed a single summary `node_fault` output. The amplifier-not-powered condition is one of these inputs and, like the others, stays latched after the supply comes back.

A built-in I/O watchdog counts down from a programmable period. It is reloaded by a refresh strobe. If it reaches zero while enabled, it records a watchdog fault in the status register and raises `stop_mode` to halt cyclic operation.

Stop mode freezes the watchdog, so no further timeouts occur while stopped. It never clears the watchdog fault itself. When the watchdog caused the stop, its fault therefore stays visible and keeps the summary fault active until software clears it. Stop mode can also be entered from an external stop input. Software leaves stop mode with a resume command.

Top module: `fault_wdog_top`

## Requirements
- R1: After reset the status register reads 0, the mask reads all ones (0x1FF), the period reads 100, control reads 0, and `stop_mode` and `node_fault` are low.
- R2: A fault input high at a clock edge sets the status bit of the same index (input i to bit i, with the amplifier-not-powered input at bit 5). The bit stays set after the input returns low.
- R3: Status bits are write-1-to-clear through register address 0. Bit 8 is the watchdog fault. Writing 0 to a bit leaves it unchanged.
- R4: If a fault input is high in the same cycle as a clear write to its bit, the bit stays set.
- R5: `node_fault` is high exactly when some status bit is set whose mask bit is also set. The mask is held at register address 1.
- R6: With the watchdog enabled (control bit 0, address 3), the period P at address 2, no refresh and no stop, two things rise at clock edge P+1 after the edge that sampled the last refresh or the enable write: status bit 8 and `stop_mode`.
- R7: A refresh strobe reloads the counter, so refreshes spaced at most P edges apart never cause a timeout.
- R8: While stopped by a watchdog timeout, the watchdog fault stays set and `node_fault` stays high (mask bit 8 set). Refreshes do not change this.
- R9: A pulse on `ext_stop` enters stop mode. While stopped, the watchdog counter is held and no watchdog fault is raised, however long the wait.
- R10: Writing 1 to control bit 1 (resume) leaves stop mode unless `ext_stop` is high in that cycle. Resume leaves the watchdog fault untouched and reloads the counter, so a new timeout comes P+1 edges after the resume edge.
- R11: `reg_rdata` returns the addressed register combinationally: status at address 0, mask at 1, period at 2, enable at bit 0 of address 3. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 8 | Fault condition inputs, bit 5 is amplifier-not-powered |
| ext_stop | input | 1 | Stop request from another source |
| wd_kick | input | 1 | Watchdog refresh strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| stop_mode | output | 1 | Cyclic operation halted |
| node_fault | output | 1 | Summary of masked status bits |

## Verification
The bound checker watches several properties on every cycle:
- Each asserted fault input lands in its status bit.
- The watchdog fault survives every cycle that lacks a clear write for it.
- A timeout pulse is always followed by stop mode together with the latched fault.
- No watchdog fault appears while stopped.
- Stop mode persists until a resume write.
- `node_fault` is never high with an empty status register.

Some behaviours only the bench scenarios can show:
- The exact timeout edge relative to refreshes and resume.
- Write-0 having no effect.
- The mask selection over many bit patterns.
- Resume being refused while `ext_stop` is held.

// File: rtl/fault_wdog_pkg.sv
package fault_wdog_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_POS     = 0;
  localparam int CTRL_RESUME_POS = 1;
endpackage

// File: rtl/fault_sticky_bank.sv
module fault_sticky_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bit_q <= 1'b0;
      else if (set_i[i])  bit_q <= 1'b1;   // a live condition beats a clear
      else if (clr_i[i])  bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             kick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             load;

  assign load = !en_i || hold_i || kick_i || reload_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= period_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign timeout_o = en_i && !hold_i && !kick_i && (cnt_q == '0);
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_stop_i,
  input  logic timeout_i,
  input  logic resume_i,
  output logic stop_o
);
  logic stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= ext_stop_i || timeout_i || (stop_q && !resume_i);
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/fault_wdog_top.sv
module fault_wdog_top
  import fault_wdog_pkg::*;
#(
  parameter int              NUM_IN     = 8,
  parameter int              CNT_W      = 16,
  parameter int              DATA_W     = 16,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] fault_in,
  input  logic              ext_stop,
  input  logic              wd_kick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              stop_mode,
  output logic              node_fault
);
  localparam int ST_W   = NUM_IN + 1;
  localparam int WD_BIT = NUM_IN;

  reg_sel_e         sel;
  logic             wr_status, wr_mask, wr_period, wr_ctrl, resume;
  logic [ST_W-1:0]  mask_q, status_q, set_vec, clr_vec;
  logic [CNT_W-1:0] period_q;
  logic             wd_en_q, wd_timeout;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_status = reg_wr && (sel == SEL_STATUS);
  assign wr_mask   = reg_wr && (sel == SEL_MASK);
  assign wr_period = reg_wr && (sel == SEL_PERIOD);
  assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
  assign resume    = wr_ctrl && reg_wdata[CTRL_RESUME_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      period_q <= DEF_PERIOD;
      wd_en_q  <= 1'b0;
    end else begin
      if (wr_mask)   mask_q   <= reg_wdata[ST_W-1:0];
      if (wr_period) period_q <= reg_wdata[CNT_W-1:0];
      if (wr_ctrl)   wd_en_q  <= reg_wdata[CTRL_EN_POS];
    end
  end

  assign set_vec = {wd_timeout, fault_in};
  assign clr_vec = wr_status ? reg_wdata[ST_W-1:0] : '0;

  fault_sticky_bank #(.W(ST_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wd_en_q),
    .hold_i    (stop_mode),
    .kick_i    (wd_kick),
    .reload_i  (resume),
    .period_i  (period_q),
    .timeout_o (wd_timeout)
  );

  stop_ctrl u_stop (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_stop_i (ext_stop),
    .timeout_i  (wd_timeout),
    .resume_i   (resume),
    .stop_o     (stop_mode)
  );

  assign node_fault = |(status_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata[ST_W-1:0]  = status_q;
      SEL_MASK:   reg_rdata[ST_W-1:0]  = mask_q;
      SEL_PERIOD: reg_rdata[CNT_W-1:0] = period_q;
      SEL_CTRL:   reg_rdata[CTRL_EN_POS] = wd_en_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_wdog_chk.sv
module fault_wdog_chk #(
  parameter int NUM_IN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] fault_in,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic              wd_clr_bit,
  input logic              resume_bit,
  input logic [NUM_IN:0]   status,
  input logic              timeout,
  input logic              stop_mode,
  input logic              node_fault
);
  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |=> ((status[NUM_IN-1:0] & $past(fault_in)) == $past(fault_in)));

  // R8
  wd_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[NUM_IN] && !(reg_wr && reg_addr == 2'd0 && wd_clr_bit)) |=> status[NUM_IN]);

  // R6
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (stop_mode && status[NUM_IN]));

  // R9
  no_wd_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> !$rose(status[NUM_IN]));

  // R10
  stop_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !(reg_wr && reg_addr == 2'd3 && resume_bit)) |=> stop_mode);

  // R5
  summary_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_fault |-> (status != '0));
endmodule

bind fault_wdog_top fault_wdog_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_in   (fault_in),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wd_clr_bit (reg_wdata[NUM_IN]),
  .resume_bit (reg_wdata[1]),
  .status     (status_q),
  .timeout    (wd_timeout),
  .stop_mode  (stop_mode),
  .node_fault (node_fault)
);

// File: tb/fault_wdog_top_bench.sv
module fault_wdog_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fault_in = '0;
  logic        ext_stop = 1'b0;
  logic        wd_kick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        stop_mode, node_fault;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_wdog_top u_fault_wdog_top (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .ext_stop(ext_stop),
    .wd_kick(wd_kick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_mode(stop_mode), .node_fault(node_fault)
  );

  // fields: fault_in[35:28] clear[27:19] mask[18:10] status[9:1] node_fault[0]
  localparam logic [35:0] VEC [8] = '{
    {8'h20, 9'h000, 9'h1FF, 9'h020, 1'b1},
    {8'h00, 9'h000, 9'h000, 9'h020, 1'b0},
    {8'h03, 9'h000, 9'h002, 9'h023, 1'b1},
    {8'h00, 9'h020, 9'h020, 9'h003, 1'b0},
    {8'h01, 9'h003, 9'h001, 9'h001, 1'b1},
    {8'h00, 9'h0FE, 9'h1FF, 9'h001, 1'b1},
    {8'h80, 9'h001, 9'h080, 9'h080, 1'b1},
    {8'h00, 9'h1FF, 9'h1FF, 9'h000, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic kick();
    wd_kick = 1'b1;
    @(negedge clk);
    wd_kick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL run-timeout R6 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R11 readback
    check("R1 stop_mode", {15'd0, stop_mode}, 16'd0);
    check("R1 node_fault", {15'd0, node_fault}, 16'd0);
    rd(2'd0, d); check("R1 status", d, 16'h0000);
    rd(2'd1, d); check("R1 mask", d, 16'h01FF);
    rd(2'd2, d); check("R11 period", d, 16'd100);
    rd(2'd3, d); check("R1 ctrl", d, 16'h0000);

    // vector table: R2 sticky, R3 w1c, R4 set wins, R5 mask
    for (int i = 0; i < 8; i++) begin
      logic [7:0] f; logic [8:0] c, m, st; logic nf;
      {f, c, m, st, nf} = VEC[i];
      wr(2'd1, {7'd0, m});
      fault_in = f; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {7'd0, c};
      @(negedge clk);
      fault_in = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(2'd0, d); check($sformatf("R2/R3/R4 status row %0d", i), d, {7'd0, st});
      check($sformatf("R5 node_fault row %0d", i), {15'd0, node_fault}, {15'd0, nf});
    end

    // watchdog
    wr(2'd1, 16'h01FF);
    wr(2'd2, 16'd10);
    rd(2'd2, d); check("R11 period write", d, 16'd10);
    wr(2'd3, 16'h0001);
    rd(2'd3, d); check("R11 ctrl enable", d, 16'h0001);
    for (int k = 0; k < 5; k++) begin
      repeat (7) @(negedge clk);
      kick();
    end
    check("R7 no timeout with refresh", {15'd0, stop_mode}, 16'd0);
    repeat (10) @(negedge clk);
    check("R6 no stop at P", {15'd0, stop_mode}, 16'd0);
    rd(2'd0, d); check("R6 no fault at P", d, 16'h0000);
    @(negedge clk);
    check("R6 stop at P+1", {15'd0, stop_mode}, 16'd1);
    rd(2'd0, d); check("R6 wd fault at P+1", d, 16'h0100);

    // R8 fault kept while stopped by watchdog
    repeat (3) kick();
    repeat (20) @(negedge clk);
    check("R8 still stopped", {15'd0, stop_mode}, 16'd1);
    rd(2'd0, d); check("R8 wd fault latched", d, 16'h0100);
    check("R8 node_fault", {15'd0, node_fault}, 16'd1);

    // R10 resume keeps fault; R3 clear
    wr(2'd3, 16'h0003);
    check("R10 resumed", {15'd0, stop_mode}, 16'd0);
    rd(2'd0, d); check("R10 fault kept on resume", d, 16'h0100);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); check("R3 write 0 no effect", d, 16'h0100);
    wr(2'd0, 16'h0100);
    rd(2'd0, d); check("R3 wd fault cleared", d, 16'h0000);
    check("R3 node_fault low", {15'd0, node_fault}, 16'd0);

    // R9 external stop holds watchdog
    ext_stop = 1'b1;
    @(negedge clk);
    ext_stop = 1'b0;
    check("R9 ext stop", {15'd0, stop_mode}, 16'd1);
    repeat (30) @(negedge clk);
    check("R9 still stopped", {15'd0, stop_mode}, 16'd1);
    rd(2'd0, d); check("R9 no wd fault", d, 16'h0000);

    // R10 resume blocked by ext_stop, then reload timing
    ext_stop = 1'b1;
    wr(2'd3, 16'h0003);
    ext_stop = 1'b0;
    @(negedge clk);
    check("R10 resume blocked", {15'd0, stop_mode}, 16'd1);
    wr(2'd3, 16'h0003);
    check("R10 resume ok", {15'd0, stop_mode}, 16'd0);
    repeat (10) @(negedge clk);
    check("R10 reload no stop at P", {15'd0, stop_mode}, 16'd0);
    @(negedge clk);
    check("R10 reload stop at P+1", {15'd0, stop_mode}, 16'd1);
    rd(2'd0, d); check("R10 wd fault after reload", d, 16'h0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule